// File: doc/BRIEF.md
# Multi-Line Memory-Fed Serial Transmitter

This block drives sixteen asynchronous serial output lines. Each line carries its own message from memory. Software gives a line a start address and a byte count through a small write port, then starts the line by writing a start mask. The block reads message bytes through a read-only request/grant memory port. It shares that port among the lines that need data, in rotating order. Each line keeps one byte in a prefetch buffer. The block adds the start bit and the stop bits to every byte, so memory holds only the data bytes. All lines shift at one common bit rate.

When a line has sent the last stop bit of its last character, its active bit drops and its done bit sets. The interrupt output is high while any done bit is set. Software reads the active and done vectors to find the line that finished, and clears done bits by writing a clear mask. The block never writes memory. Several lines can therefore point at the same buffer and send it at the same time.

Top module: `mltx_top`

## Requirements
- R1: A write with `cfg_sel`=0 loads the address of line `cfg_line` from `cfg_wdata`, and `cfg_sel`=1 loads its byte count. Either write is ignored while that line is active.
- R2: A write with `cfg_sel`=2 starts every line whose bit is set in `cfg_wdata`. A started line with a nonzero count shows `line_active` high on the next cycle. A line started with a zero count instead sets its `line_done` bit on the next cycle, stays inactive and makes no memory request.
- R3: A line fetches bytes from its start address upward, one address per byte. It sends exactly the programmed count of bytes, in address order.
- R4: Each character is sent as a 0 start bit, then 8 data bits with the least significant bit first, then stop bits at 1. There are two stop bits when `two_stop` is 1 at the moment the character is loaded, and one stop bit otherwise. Every bit lasts `BAUD_DIV` clock cycles.
- R5: A line that is not active holds its output at 1.
- R6: `line_active` of a line drops only after the final stop bit of its last character has been fully sent. `line_done` of that line sets on the same clock edge.
- R7: `irq` goes high one cycle after any done bit is set. It goes low one cycle after all done bits are clear. A write with `cfg_sel`=3 clears the done bits selected by the mask in `cfg_wdata`.
- R8: `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_grant` is high. `mem_rdata` is taken in the cycle after that grant. Only one read is outstanding at a time. Lines that share one address each send the full message.
- R9: After reset every line output is 1, and `line_active`, `line_done`, `irq` and `mem_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 address, 1 count, 2 start mask, 3 done-clear mask |
| cfg_line | input | 4 | Line number for address and count writes |
| cfg_wdata | input | 16 | Write data or line mask |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read byte address |
| mem_grant | input | 1 | Memory accepts the request |
| mem_rdata | input | 8 | Read data, valid the cycle after grant |
| tx_line | output | 16 | Serial outputs, one per line |
| line_active | output | 16 | Lines still sending |
| line_done | output | 16 | Lines that have finished |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the memory follows the stated handshake. Read data comes back exactly one cycle after grant, and grant is only raised while a request is pending. The bench memory model keeps to this: it raises grant only when it sees `mem_req`, with a latency that cycles through 0, 1 and 2. It drops grant in the next cycle and presents the data that follows. Configuration writes are one cycle long and never overlap. Address and count writes to an active line are made deliberately, to show that they are ignored.

// File: rtl/mltx_pkg.sv
package mltx_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_START = 2'd2,
    SEL_CLEAR = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_DATA = 2'd2
  } fetch_state_e;

endpackage

// File: rtl/mltx_baud.sv
module mltx_baud #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(DIV - 1));
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mltx_rr.sv
module mltx_rr #(
  parameter int N = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [N-1:0]                     req,
  input  logic                             adv,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] pick,
  output logic                             any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;

  // smallest offset from the pointer wins: scan downward so it is written last
  always_comb begin
    int cand;
    any  = 1'b0;
    pick = ptr;
    for (int off = N - 1; off >= 0; off--) begin
      cand = int'(ptr) + off;
      if (cand >= N) cand = cand - N;
      if (req[cand]) begin
        any  = 1'b1;
        pick = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (pick == IW'(N - 1)) ? '0 : pick + 1'b1;
  end
endmodule

// File: rtl/mltx_lane.sv
module mltx_lane #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              start,
  input  logic              clear,
  input  logic              sel,
  input  logic              grant,
  input  logic              fill,
  input  logic [DATA_W-1:0] rdata,
  input  logic              tick,
  input  logic              two_stop,
  output logic              need,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              tx,
  output logic              active,
  output logic              done
);
  localparam int SH_W = DATA_W + 2;
  localparam int BL_W = $clog2(DATA_W + 3);

  logic [CNT_W-1:0]  cnt;
  logic              pend;
  logic              buf_full;
  logic [DATA_W-1:0] buf_q;
  logic [SH_W-1:0]   shreg;
  logic [BL_W-1:0]   bits_left;
  logic              finish;

  assign need   = active && (cnt != '0) && !pend && !buf_full;
  assign finish = active && (cnt == '0) && !pend && !buf_full &&
                  (bits_left == '0) && tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      done      <= 1'b0;
      pend      <= 1'b0;
      buf_full  <= 1'b0;
      buf_q     <= '0;
      shreg     <= '1;
      bits_left <= '0;
      tx        <= 1'b1;
    end else begin
      // software loads, only while idle
      if (wr_addr && !active) cur_addr <= addr_in;
      if (wr_cnt && !active)  cnt      <= cnt_in;
      if (grant) begin
        cur_addr <= cur_addr + 1'b1;
        cnt      <= cnt - 1'b1;
      end

      // fetch bookkeeping
      if (sel) pend <= 1'b1;
      if (fill) begin
        pend     <= 1'b0;
        buf_full <= 1'b1;
        buf_q    <= rdata;
      end

      // serializer on the shared bit tick
      if (tick) begin
        if (bits_left != '0) begin
          tx        <= shreg[0];
          shreg     <= {1'b1, shreg[SH_W-1:1]};
          bits_left <= bits_left - 1'b1;
        end else if (buf_full) begin
          tx        <= 1'b0;
          shreg     <= {2'b11, buf_q};
          bits_left <= two_stop ? BL_W'(DATA_W + 2) : BL_W'(DATA_W + 1);
          buf_full  <= 1'b0;
        end else begin
          tx <= 1'b1;
        end
      end

      // start, clear, completion
      if (start && !active) begin
        if (cnt == '0) done   <= 1'b1;
        else           active <= 1'b1;
      end
      if (clear) done <= 1'b0;
      if (finish) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mltx_top.sv
module mltx_top #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 8,
  parameter int BAUD_DIV  = 16,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AC_W     = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
  localparam int WD_W     = (AC_W > NUM_LINES) ? AC_W : NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [LINE_W-1:0]    cfg_line,
  input  logic [WD_W-1:0]      cfg_wdata,
  input  logic                 two_stop,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_grant,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [NUM_LINES-1:0] tx_line,
  output logic [NUM_LINES-1:0] line_active,
  output logic [NUM_LINES-1:0] line_done,
  output logic                 irq
);
  import mltx_pkg::*;

  logic                 tick;
  logic [NUM_LINES-1:0] need;
  logic [LINE_W-1:0]    pick;
  logic                 any_need;
  logic                 issue;
  logic [ADDR_W-1:0]    lane_addr [NUM_LINES];
  fetch_state_e         fstate;
  logic [LINE_W-1:0]    fsel;

  mltx_baud #(.DIV(BAUD_DIV)) u_baud (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  mltx_rr #(.N(NUM_LINES)) u_rr (
    .clk (clk),
    .rst (rst),
    .req (need),
    .adv (issue),
    .pick(pick),
    .any (any_need)
  );

  assign issue = (fstate == FS_IDLE) && any_need;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
      logic is_cfg;
      assign is_cfg = cfg_we && (cfg_line == LINE_W'(i));

      mltx_lane #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
      ) u_lane (
        .clk     (clk),
        .rst     (rst),
        .wr_addr (is_cfg && (cfg_sel == SEL_ADDR)),
        .wr_cnt  (is_cfg && (cfg_sel == SEL_COUNT)),
        .addr_in (cfg_wdata[ADDR_W-1:0]),
        .cnt_in  (cfg_wdata[CNT_W-1:0]),
        .start   (cfg_we && (cfg_sel == SEL_START) && cfg_wdata[i]),
        .clear   (cfg_we && (cfg_sel == SEL_CLEAR) && cfg_wdata[i]),
        .sel     (issue && (pick == LINE_W'(i))),
        .grant   ((fstate == FS_REQ) && mem_grant && (fsel == LINE_W'(i))),
        .fill    ((fstate == FS_DATA) && (fsel == LINE_W'(i))),
        .rdata   (mem_rdata),
        .tick    (tick),
        .two_stop(two_stop),
        .need    (need[i]),
        .cur_addr(lane_addr[i]),
        .tx      (tx_line[i]),
        .active  (line_active[i]),
        .done    (line_done[i])
      );
    end
  endgenerate

  // single outstanding read, shared by all lines
  always_ff @(posedge clk) begin
    if (rst) begin
      fstate   <= FS_IDLE;
      fsel     <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      case (fstate)
        FS_IDLE: if (any_need) begin
          fsel     <= pick;
          mem_addr <= lane_addr[pick];
          mem_req  <= 1'b1;
          fstate   <= FS_REQ;
        end
        FS_REQ: if (mem_grant) begin
          mem_req <= 1'b0;
          fstate  <= FS_DATA;
        end
        default: fstate <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |line_done;
  end
endmodule

// File: rtl/mltx_chk.sv
module mltx_chk #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mem_req,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic                 mem_grant,
  input logic [NUM_LINES-1:0] tx_line,
  input logic [NUM_LINES-1:0] line_active,
  input logic [NUM_LINES-1:0] line_done
);
  // R8: request held with a stable address until granted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_grant) |=> (mem_req && $stable(mem_addr)));

  // R2: no fetch is ever made with no line active
  assert_req_needs_line_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (line_active != '0));

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      // R5: inactive lines sit at mark
      assert_idle_mark_R5: assert property (@(posedge clk) disable iff (rst)
        !line_active[i] |-> tx_line[i]);
      // R6: completion raises the done flag on the same edge
      assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(line_active[i]) |-> line_done[i]);
    end
  endgenerate
endmodule

bind mltx_top mltx_chk #(
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_grant  (mem_grant),
  .tx_line    (tx_line),
  .line_active(line_active),
  .line_done  (line_done)
);

// File: tb/mltx_top_test.sv
module mltx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 16;
  localparam int BD   = 8;
  localparam int HALF = BD / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [3:0]    cfg_line = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          two_stop = 1'b0;
  logic          mem_req;
  logic [15:0]   mem_addr;
  logic          mem_grant = 1'b0;
  logic [7:0]    mem_rdata = '0;
  logic [NL-1:0] tx_line;
  logic [NL-1:0] line_active;
  logic [NL-1:0] line_done;
  logic          irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [7:0] expq [NL][$];
  int rxcnt  [NL];
  int target [NL];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mltx_top #(.BAUD_DIV(BD)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_line(cfg_line), .cfg_wdata(cfg_wdata), .two_stop(two_stop),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_grant(mem_grant),
    .mem_rdata(mem_rdata), .tx_line(tx_line), .line_active(line_active),
    .line_done(line_done), .irq(irq)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input int ln, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_line = 4'(ln); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: program a line and queue its expected bytes
  task automatic load_line(input int ln, input logic [15:0] a, input int n);
    cfg_write(2'd0, ln, a);
    cfg_write(2'd1, ln, 16'(n));
    for (int j = 0; j < n; j++) expq[ln].push_back(mem_fn(a + 16'(j)));
    target[ln] = rxcnt[ln] + n;
  endtask

  // memory model: grant after 0..2 cycles, data one cycle after grant
  initial begin
    int lat = 0;
    logic [15:0] cap;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_grant) begin
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 3;
        cap = mem_addr;
        mem_grant = 1'b1;
        @(negedge clk);
        mem_grant = 1'b0;
        mem_rdata = mem_fn(cap);
      end
    end
  end

  // monitor: decode each line and compare with the scoreboard
  task automatic mon(input int k);
    logic [7:0] got;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      if (!rst && tx_line[k] == 1'b0) begin
        repeat (HALF) @(negedge clk);
        chk(tx_line[k] == 1'b0, "R4 start bit", tx_line[k], 0);
        for (int b = 0; b < 8; b++) begin
          repeat (BD) @(negedge clk);
          got[b] = tx_line[k];
        end
        repeat (BD) @(negedge clk);
        chk(tx_line[k] == 1'b1, "R4 first stop bit", tx_line[k], 1);
        if (two_stop) begin
          repeat (BD) @(negedge clk);
          chk(tx_line[k] == 1'b1, "R4 second stop bit", tx_line[k], 1);
        end
        if (expq[k].size() == 0) begin
          chk(1'b0, "R3 unexpected character", got, k);
        end else begin
          exp = expq[k].pop_front();
          chk(got == exp, "R3 R4 character value", got, exp);
        end
        rxcnt[k]++;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      rxcnt[i] = 0;
      target[i] = 0;
    end
    for (int i = 0; i < NL; i++) begin
      automatic int k = i;
      fork mon(k); join_none
    end
  end

  // R6: a line may go inactive only once all its characters are out
  initial begin
    logic [NL-1:0] prev = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NL; i++)
        if (prev[i] && !line_active[i])
          chk(rxcnt[i] == target[i], "R6 active dropped before last stop bit",
              rxcnt[i], target[i]);
      prev = line_active;
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(tx_line == '1, "R9 outputs at mark", tx_line, 16'hFFFF);
    chk(line_active == '0, "R9 active clear", line_active, 0);
    chk(line_done == '0, "R9 done clear", line_done, 0);
    chk(irq == 1'b0, "R9 irq low", irq, 0);
    chk(mem_req == 1'b0, "R9 no request", mem_req, 0);

    // phase 1: one line, one stop bit
    load_line(3, 16'h0100, 4);
    cfg_write(2'd2, 0, 16'h0008);
    chk(line_active[3] == 1'b1, "R2 line active after start", line_active[3], 1);
    while (line_active[3]) @(negedge clk);
    chk(line_done[3] == 1'b1, "R6 done with active drop", line_done[3], 1);
    chk(irq == 1'b0, "R7 irq registered one cycle later", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq raised", irq, 1);
    chk(rxcnt[3] == 4, "R3 byte total line 3", rxcnt[3], 4);
    cfg_write(2'd3, 0, 16'h0008);
    chk(line_done[3] == 1'b0, "R7 done cleared", line_done[3], 0);
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq dropped", irq, 0);

    // phase 2: shared buffer on three lines, two stop bits
    two_stop = 1'b1;
    load_line(0, 16'h0200, 3);
    load_line(5, 16'h0200, 3);
    load_line(15, 16'h0200, 3);
    load_line(7, 16'h0300, 2);
    cfg_write(2'd2, 0, 16'h80A1);
    chk(line_active == 16'h80A1, "R2 all four started", line_active, 16'h80A1);
    // R1: writes to an active line are ignored
    cfg_write(2'd0, 7, 16'h0999);
    cfg_write(2'd1, 7, 16'd50);
    while (line_active != '0) @(negedge clk);
    chk(line_done == 16'h80A1, "R6 done set on four lines", line_done, 16'h80A1);
    chk(rxcnt[7] == 2, "R1 line 7 kept its count", rxcnt[7], 2);
    chk(rxcnt[0] == 3 && rxcnt[5] == 3 && rxcnt[15] == 3,
        "R8 shared buffer sent on each line", rxcnt[5], 3);
    cfg_write(2'd3, 0, 16'hFFFF);
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq low after clearing all", irq, 0);

    // phase 3: start with zero count
    cfg_write(2'd1, 9, 16'd0);
    cfg_write(2'd2, 0, 16'h0200);
    chk(line_done[9] == 1'b1, "R2 zero count sets done", line_done[9], 1);
    chk(line_active[9] == 1'b0, "R2 zero count stays inactive", line_active[9], 0);
    begin
      bit saw = 1'b0;
      repeat (4 * BD) begin
        @(negedge clk);
        if (mem_req) saw = 1'b1;
      end
      chk(!saw, "R2 zero count makes no fetch", saw, 0);
    end
    chk(tx_line[9] == 1'b1, "R5 zero count line at mark", tx_line[9], 1);
    chk(irq == 1'b1, "R7 irq from zero-count done", irq, 1);

    for (int i = 0; i < NL; i++)
      chk(expq[i].size() == 0, "R3 scoreboard drained", expq[i].size(), 0);
    summary();
  end
endmodule